// File: doc/BRIEF.md
# JTAG Scan-Chain Device Enumerator

This block is a JTAG master that finds out which devices sit on a scan chain that has no dedicated TAP reset pin. On a start pulse it brings every TAP into Test-Logic-Reset using TMS alone. In that state each device selects its IDCODE register, or its 1-bit BYPASS register if it has no IDCODE. The block then walks the TAPs into Shift-DR and clocks a marker pattern through the chain: a run of ones followed by zeros. While doing this it decodes the bits that come back on TDO. The captured bits start with the data registers of the devices, with the device nearest TDO first, and end with the returning marker.

A captured entry that starts with a 1 is a 32-bit IDCODE, least significant bit first. An entry that starts with a 0 is a BYPASS device. A 32-bit entry whose low eight bits are all ones is taken as the marker, because no valid IDCODE has that pattern, and it ends the decode. After the scan the block leaves through Exit1-DR and Update-DR to Run-Test/Idle and parks TCK low. It then raises `done` and presents the device count, the number of IDCODEs and a read port for the stored IDCODEs. It flags an overflow when there are more IDCODEs than it can store. It flags a missing chain when TDO never changed or the marker never came back.

Controller states, in order: `ST_IDLE` goes to `ST_RESET` on start. `ST_RESET` drives TMS high for RESET_EDGES rising edges, then goes to `ST_TO_RTI` (TMS 0). From there the order is `ST_TO_SEL` (TMS 1), `ST_TO_CAP` (TMS 0) and `ST_TO_SHIFT` (TMS 0). `ST_SHIFT` lasts SHIFT_LEN rising edges, with TMS 1 on the last one. `ST_TO_UPD` drives TMS 1, then `ST_TO_IDLE` drives TMS 0. `ST_TAIL` waits for the final TCK falling edge and then returns to `ST_IDLE`. Decoder states: `DC_HDR` waits for the first bit of an entry, `DC_ID` collects the rest of an IDCODE, and `DC_END` is entered once the marker is seen.

Top module: `jtag_chain_enum`

## Requirements
- R1: After reset, `tck` is 0, `tms` is 1, `tdi` is 0, and `busy`, `done`, `no_chain`, `overflow`, `dev_count` and `id_count` are all 0.
- R2: A start pulse drives TMS high for exactly RESET_EDGES (default 5) rising edges of TCK, then TMS 0,1,0,0, so that the TAPs reach Shift-DR from whatever state they were in before.
- R3: TCK has a period of 2*CLK_DIV system clocks. TMS and TDI change only while TCK is low. TDO is sampled at the rising edge of TCK.
- R4: Shift-DR lasts exactly SHIFT_LEN rising edges. TDI is 1 for the first 8 shifted bits and 0 after that, and TMS is 1 on the last shifted bit.
- R5: After shifting, TMS goes 1 then 0, which leaves the TAPs in Run-Test/Idle. TCK then stays low, `done` rises and `busy` falls.
- R6: In the captured TDO stream, an entry starting with 0 counts as one BYPASS device. An entry starting with 1 is a 32-bit IDCODE, received LSB first.
- R7: A 32-bit entry whose bits [7:0] are all ones is the returning marker. It stops the decode and is not counted as a device.
- R8: `dev_count` is the number of entries (IDCODE plus BYPASS) before the marker, and `id_count` is the number of IDCODEs stored.
- R9: `rd_data` returns the IDCODE at index `rd_addr`, with index 0 being the device nearest TDO. Slots not written in the latest scan read 0, because the store is cleared at start.
- R10: When a chain holds more than MAX_IDS IDCODEs, `overflow` is 1 and `id_count` equals MAX_IDS. The first MAX_IDS IDCODEs are kept, and `dev_count` still counts every device.
- R11: If all captured bits are equal, or the marker is never found, `no_chain` is 1 and `dev_count`, `id_count` and `overflow` read 0.
- R12: `busy` is high from the accepted start until `done`. A start pulse while busy is ignored. `done` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a scan |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to the chain |
| tdo | input | 1 | JTAG data from the chain |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Results valid |
| no_chain | output | 1 | Chain missing or stuck |
| overflow | output | 1 | More IDCODEs than storage |
| dev_count | output | clog2(SHIFT_LEN+1) | Devices found |
| id_count | output | clog2(MAX_IDS+1) | IDCODEs stored |
| rd_addr | input | clog2(MAX_IDS) | IDCODE read index |
| rd_data | output | 32 | IDCODE at rd_addr |

## Verification
The properties assume that `tdo` changes only in response to TCK, and that `start` is a single-cycle pulse. The bench meets this with a chain model that updates TDO on TCK falling edges only, and drives `start` for one cycle at a falling system clock edge. The stuck cases hold TDO at a constant level for the whole scan. The stored IDCODEs are chosen so that none has eight ones in its low byte, which keeps every device entry distinct from the marker.

// File: rtl/jce_pkg.sv
`timescale 1ns/1ps
package jce_pkg;
    localparam int IDW       = 32;
    localparam int MARK_ONES = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RESET, ST_TO_RTI, ST_TO_SEL, ST_TO_CAP,
        ST_TO_SHIFT, ST_SHIFT, ST_TO_UPD, ST_TO_IDLE, ST_TAIL
    } scan_st_t;

    typedef enum logic [1:0] {
        DC_HDR, DC_ID, DC_END
    } dec_st_t;
endpackage

// File: rtl/jce_tck_gen.sv
`timescale 1ns/1ps
module jce_tck_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise,
    output logic fall
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tck_q;
    logic          wrap;

    assign wrap = run && (cnt == CW'(CLK_DIV - 1));
    assign rise = wrap && !tck_q;
    assign fall = wrap && tck_q;
    assign tck  = tck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            tck_q <= 1'b0;
        end else if (!run) begin
            cnt   <= '0;
            tck_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            tck_q <= ~tck_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/jce_decoder.sv
`timescale 1ns/1ps
module jce_decoder
    import jce_pkg::*;
#(
    parameter int MAX_IDS = 8,
    parameter int CNT_W   = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         bit_vld,
    input  logic                         bit_val,
    output logic                         wr_en,
    output logic [$clog2(MAX_IDS)-1:0]   wr_idx,
    output logic [IDW-1:0]               wr_data,
    output logic [CNT_W-1:0]             dev_cnt,
    output logic [$clog2(MAX_IDS+1)-1:0] id_cnt,
    output logic                         ovf,
    output logic                         mark_found,
    output logic                         seen0,
    output logic                         seen1
);
    localparam int ICW = $clog2(MAX_IDS + 1);
    localparam int AW  = $clog2(MAX_IDS);

    dec_st_t        dst;
    logic [IDW-1:0] sreg;
    logic [4:0]     bcnt;
    logic [IDW-1:0] word;
    logic           is_mark;
    logic           last_bit;
    logic           room;

    assign word     = {bit_val, sreg[IDW-1:1]};
    assign is_mark  = &word[MARK_ONES-1:0];
    assign last_bit = (bcnt == 5'd31);
    assign room     = (id_cnt < ICW'(MAX_IDS));

    assign wr_en   = bit_vld && (dst == DC_ID) && last_bit && !is_mark && room;
    assign wr_idx  = id_cnt[AW-1:0];
    assign wr_data = word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst        <= DC_HDR;
            sreg       <= '0;
            bcnt       <= '0;
            dev_cnt    <= '0;
            id_cnt     <= '0;
            ovf        <= 1'b0;
            mark_found <= 1'b0;
            seen0      <= 1'b0;
            seen1      <= 1'b0;
        end else if (clear) begin
            dst        <= DC_HDR;
            sreg       <= '0;
            bcnt       <= '0;
            dev_cnt    <= '0;
            id_cnt     <= '0;
            ovf        <= 1'b0;
            mark_found <= 1'b0;
            seen0      <= 1'b0;
            seen1      <= 1'b0;
        end else if (bit_vld) begin
            seen0 <= seen0 | !bit_val;
            seen1 <= seen1 | bit_val;
            unique case (dst)
                DC_HDR: begin
                    if (bit_val) begin
                        sreg <= word;
                        bcnt <= 5'd1;
                        dst  <= DC_ID;
                    end else begin
                        dev_cnt <= dev_cnt + 1'b1;
                    end
                end
                DC_ID: begin
                    sreg <= word;
                    bcnt <= bcnt + 1'b1;
                    if (last_bit) begin
                        if (is_mark) begin
                            mark_found <= 1'b1;
                            dst        <= DC_END;
                        end else begin
                            dev_cnt <= dev_cnt + 1'b1;
                            if (room) id_cnt <= id_cnt + 1'b1;
                            else      ovf    <= 1'b1;
                            dst <= DC_HDR;
                        end
                    end
                end
                DC_END: begin
                    dst <= DC_END;
                end
                default: dst <= DC_HDR;
            endcase
        end
    end
endmodule

// File: rtl/jce_id_store.sv
`timescale 1ns/1ps
module jce_id_store
    import jce_pkg::*;
#(
    parameter int MAX_IDS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [$clog2(MAX_IDS)-1:0] wr_idx,
    input  logic [IDW-1:0]             wr_data,
    input  logic [$clog2(MAX_IDS)-1:0] rd_addr,
    output logic [IDW-1:0]             rd_data
);
    logic [IDW-1:0] slot [MAX_IDS];

    for (genvar g = 0; g < MAX_IDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (clear)
                slot[g] <= '0;
            else if (wr_en && (int'(wr_idx) == g))
                slot[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < MAX_IDS; i++)
            if (int'(rd_addr) == i) rd_data = slot[i];
    end
endmodule

// File: rtl/jtag_chain_enum.sv
`timescale 1ns/1ps
module jtag_chain_enum
    import jce_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int RESET_EDGES = 5,
    parameter int SHIFT_LEN   = 268,
    parameter int MAX_IDS     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    output logic                           tck,
    output logic                           tms,
    output logic                           tdi,
    input  logic                           tdo,
    output logic                           busy,
    output logic                           done,
    output logic                           no_chain,
    output logic                           overflow,
    output logic [$clog2(SHIFT_LEN+1)-1:0] dev_count,
    output logic [$clog2(MAX_IDS+1)-1:0]   id_count,
    input  logic [$clog2(MAX_IDS)-1:0]     rd_addr,
    output logic [IDW-1:0]                 rd_data
);
    localparam int RCW = $clog2(RESET_EDGES + 1);
    localparam int BCW = $clog2(SHIFT_LEN + 1);
    localparam int ICW = $clog2(MAX_IDS + 1);
    localparam int AW  = $clog2(MAX_IDS);

    scan_st_t       state, nxt;
    logic [RCW-1:0] rst_cnt;
    logic [BCW-1:0] bit_cnt;
    logic           rise_t, fall_t;
    logic           start_ok;
    logic           done_q;
    logic           tms_q, tdi_q;
    logic           drv_tms, drv_tdi;
    logic           last_shift;

    logic           wr_en;
    logic [AW-1:0]  wr_idx;
    logic [IDW-1:0] wr_data;
    logic [BCW-1:0] dec_dev;
    logic [ICW-1:0] dec_ids;
    logic           dec_ovf, mark_found, seen0, seen1;
    logic           chain_bad, good;

    assign start_ok   = start && (state == ST_IDLE);
    assign last_shift = (bit_cnt == BCW'(SHIFT_LEN - 1));

    jce_tck_gen #(.CLK_DIV(CLK_DIV)) u_tck (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != ST_IDLE),
        .tck  (tck),
        .rise (rise_t),
        .fall (fall_t)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_RESET;
            ST_RESET:    if (rise_t && rst_cnt == RCW'(RESET_EDGES - 1)) nxt = ST_TO_RTI;
            ST_TO_RTI:   if (rise_t) nxt = ST_TO_SEL;
            ST_TO_SEL:   if (rise_t) nxt = ST_TO_CAP;
            ST_TO_CAP:   if (rise_t) nxt = ST_TO_SHIFT;
            ST_TO_SHIFT: if (rise_t) nxt = ST_SHIFT;
            ST_SHIFT:    if (rise_t && last_shift) nxt = ST_TO_UPD;
            ST_TO_UPD:   if (rise_t) nxt = ST_TO_IDLE;
            ST_TO_IDLE:  if (rise_t) nxt = ST_TAIL;
            ST_TAIL:     if (fall_t) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register with its step counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rst_cnt <= '0;
            bit_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                rst_cnt <= '0;
                bit_cnt <= '0;
            end else if (rise_t) begin
                if (state == ST_RESET) rst_cnt <= rst_cnt + 1'b1;
                if (state == ST_SHIFT) bit_cnt <= bit_cnt + 1'b1;
            end
            if (start_ok)
                done_q <= 1'b0;
            else if (state == ST_TAIL && fall_t)
                done_q <= 1'b1;
        end
    end

    // pin values for the coming rising edge
    always_comb begin
        drv_tms = 1'b0;
        drv_tdi = 1'b0;
        unique case (state)
            ST_RESET, ST_TO_SEL, ST_TO_UPD: drv_tms = 1'b1;
            ST_SHIFT: begin
                drv_tms = last_shift;
                drv_tdi = (bit_cnt < BCW'(MARK_ONES));
            end
            default: drv_tms = 1'b0;
        endcase
    end

    // output register, updated on TCK falling edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tms_q <= 1'b1;
            tdi_q <= 1'b0;
        end else if (start_ok) begin
            tms_q <= 1'b1;
            tdi_q <= 1'b0;
        end else if (fall_t) begin
            tms_q <= drv_tms;
            tdi_q <= drv_tdi;
        end
    end

    jce_decoder #(.MAX_IDS(MAX_IDS), .CNT_W(BCW)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .bit_vld   (rise_t && state == ST_SHIFT),
        .bit_val   (tdo),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .dev_cnt   (dec_dev),
        .id_cnt    (dec_ids),
        .ovf       (dec_ovf),
        .mark_found(mark_found),
        .seen0     (seen0),
        .seen1     (seen1)
    );

    jce_id_store #(.MAX_IDS(MAX_IDS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_ok),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    assign chain_bad = !mark_found || !(seen0 && seen1);
    assign good      = done_q && !chain_bad;

    assign tms       = tms_q;
    assign tdi       = tdi_q;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign no_chain  = done_q && chain_bad;
    assign overflow  = good && dec_ovf;
    assign dev_count = good ? dec_dev : '0;
    assign id_count  = good ? dec_ids : '0;
endmodule

// File: rtl/jce_checker.sv
`timescale 1ns/1ps
module jce_checker #(
    parameter int MAX_IDS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tck,
    input logic                         tms,
    input logic                         tdi,
    input logic                         busy,
    input logic                         done,
    input logic                         no_chain,
    input logic                         overflow,
    input logic [$clog2(MAX_IDS+1)-1:0] id_count
);
    // R3
    tms_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> !tck);

    // R3
    tdi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdi) |-> !tck);

    // R5
    tck_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R12
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R11
    no_chain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_chain |-> (done && !overflow));

    // R10
    overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (int'(id_count) == MAX_IDS));
endmodule

bind jtag_chain_enum jce_checker #(.MAX_IDS(MAX_IDS)) u_jce_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tck     (tck),
    .tms     (tms),
    .tdi     (tdi),
    .busy    (busy),
    .done    (done),
    .no_chain(no_chain),
    .overflow(overflow),
    .id_count(id_count)
);

// File: tb/test_jtag_chain_enum.sv
`timescale 1ns/1ps
module test_jtag_chain_enum;
    localparam int CLK_DIV     = 4;
    localparam int RESET_EDGES = 5;
    localparam int SHIFT_LEN   = 340;
    localparam int MAX_IDS     = 8;
    localparam int DCW = $clog2(SHIFT_LEN + 1);
    localparam int ICW = $clog2(MAX_IDS + 1);
    localparam int AW  = $clog2(MAX_IDS);

    // TAP state codes for the chain model
    localparam int T_TLR = 0,  T_RTI = 1,  T_SDR = 2,  T_CDR = 3;
    localparam int T_SHD = 4,  T_E1D = 5,  T_PDR = 6,  T_E2D = 7;
    localparam int T_UDR = 8,  T_SIR = 9,  T_CIR = 10, T_SHI = 11;
    localparam int T_E1I = 12, T_PIR = 13, T_E2I = 14, T_UIR = 15;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           tck, tms, tdi, tdo;
    logic           busy, done, no_chain, overflow;
    logic [DCW-1:0] dev_count;
    logic [ICW-1:0] id_count;
    logic [AW-1:0]  rd_addr = '0;
    logic [31:0]    rd_data;

    jtag_chain_enum #(
        .CLK_DIV(CLK_DIV), .RESET_EDGES(RESET_EDGES),
        .SHIFT_LEN(SHIFT_LEN), .MAX_IDS(MAX_IDS)
    ) i_jtag_chain_enum (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .busy(busy), .done(done), .no_chain(no_chain), .overflow(overflow),
        .dev_count(dev_count), .id_count(id_count),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- chain model ----------------
    int           mode = 0;          // 0 normal, 1 TDO stuck low, 2 TDO stuck high
    int           ndev = 0;
    bit           is_id [16];
    logic [31:0]  code  [16];
    int           tap_st = T_TLR;
    logic [511:0] dr = '0;
    int           dr_len = 0;
    logic         tdo_m = 1'b1;
    int           hi_run = 0, first_run = -1;
    int           shift_cnt = 0, tdi_ones_head = 0, tdi_ones_tail = 0;
    real          t_rise_prev = 0.0, t_rise_last = 0.0;

    assign tdo = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : tdo_m;

    function automatic int tap_next(input int s, input logic m);
        case (s)
            T_TLR: return m ? T_TLR : T_RTI;
            T_RTI: return m ? T_SDR : T_RTI;
            T_SDR: return m ? T_SIR : T_CDR;
            T_CDR: return m ? T_E1D : T_SHD;
            T_SHD: return m ? T_E1D : T_SHD;
            T_E1D: return m ? T_UDR : T_PDR;
            T_PDR: return m ? T_E2D : T_PDR;
            T_E2D: return m ? T_UDR : T_SHD;
            T_UDR: return m ? T_SDR : T_RTI;
            T_SIR: return m ? T_TLR : T_CIR;
            T_CIR: return m ? T_E1I : T_SHI;
            T_SHI: return m ? T_E1I : T_SHI;
            T_E1I: return m ? T_UIR : T_PIR;
            T_PIR: return m ? T_E2I : T_PIR;
            T_E2I: return m ? T_UIR : T_SHI;
            default: return m ? T_SDR : T_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        t_rise_prev = t_rise_last;
        t_rise_last = $realtime;
        if (tms) hi_run++;
        else begin
            if (first_run < 0) first_run = hi_run;
            hi_run = 0;
        end
        if (tap_st == T_SHD) begin
            if (shift_cnt < 8) begin if (tdi) tdi_ones_head++; end
            else if (tdi) tdi_ones_tail++;
            shift_cnt++;
            for (int i = 0; i < dr_len - 1; i++) dr[i] = dr[i+1];
            if (dr_len > 0) dr[dr_len-1] = tdi;
        end
        if (tap_st == T_CDR) begin
            int p;
            p  = 0;
            dr = '0;
            for (int d = 0; d < ndev; d++) begin
                if (is_id[d]) begin
                    for (int b = 0; b < 32; b++) dr[p+b] = code[d][b];
                    p += 32;
                end else begin
                    dr[p] = 1'b0;
                    p++;
                end
            end
            dr_len = p;
        end
        tap_st = tap_next(tap_st, tms);
    end

    always @(negedge tck) tdo_m = (tap_st == T_SHD) ? dr[0] : 1'b1;

    // ---------------- scoreboard ----------------
    typedef struct {
        int          kind;   // 0 dev_count 1 id_count 2 no_chain 3 overflow 4 rd_data
        int          addr;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    bit   mon_done = 1'b0;

    initial begin
        forever begin
            @(posedge done);
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                case (e.kind)
                    0: chk(e.req, "dev_count", 32'(dev_count), e.val);
                    1: chk(e.req, "id_count",  32'(id_count),  e.val);
                    2: chk(e.req, "no_chain",  32'(no_chain),  e.val);
                    3: chk(e.req, "overflow",  32'(overflow),  e.val);
                    default: begin
                        rd_addr = AW'(e.addr);
                        #1;
                        chk(e.req, $sformatf("rd_data[%0d]", e.addr), rd_data, e.val);
                    end
                endcase
            end
            mon_done = 1'b1;
        end
    end

    function automatic exp_t mk(input int k, input int a, input logic [31:0] v, input string r);
        exp_t e;
        e.kind = k; e.addr = a; e.val = v; e.req = r;
        return e;
    endfunction

    task automatic run_scan(input int tap_start, input bit poke_start);
        int nid, slot;
        nid = 0;
        for (int d = 0; d < ndev; d++) if (is_id[d]) nid++;
        if (mode != 0) begin
            q.push_back(mk(2, 0, 32'd1, "R11"));
            q.push_back(mk(0, 0, 32'd0, "R11"));
            q.push_back(mk(1, 0, 32'd0, "R11"));
            q.push_back(mk(3, 0, 32'd0, "R11"));
        end else begin
            q.push_back(mk(2, 0, 32'd0, "R11"));
            q.push_back(mk(0, 0, 32'(ndev), "R8"));
            q.push_back(mk(1, 0, 32'((nid > MAX_IDS) ? MAX_IDS : nid), "R10"));
            q.push_back(mk(3, 0, 32'(nid > MAX_IDS), "R10"));
            slot = 0;
            for (int d = 0; d < ndev; d++)
                if (is_id[d] && slot < MAX_IDS) begin
                    q.push_back(mk(4, slot, code[d], "R6"));
                    slot++;
                end
            for (int s = slot; s < MAX_IDS; s++) q.push_back(mk(4, s, 32'd0, "R9"));
        end
        tap_st = tap_start;
        hi_run = 0; first_run = -1;
        shift_cnt = 0; tdi_ones_head = 0; tdi_ones_tail = 0;
        mon_done = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke_start) begin
            repeat (400) @(negedge clk);
            start = 1'b1;                       // R12: ignored while busy
            @(negedge clk); start = 1'b0;
        end
        wait (mon_done);
        @(negedge clk);
        chk("R2", "TMS-high edges before leaving reset", 32'(first_run), 32'(RESET_EDGES));
        chk("R4", "shift length", 32'(shift_cnt), 32'(SHIFT_LEN));
        chk("R4", "TDI ones in marker head", 32'(tdi_ones_head), 32'd8);
        chk("R4", "TDI ones after head", 32'(tdi_ones_tail), 32'd0);
        chk("R5", "final TAP state", 32'(tap_st), 32'(T_RTI));
        chk("R5", "tck parked", 32'(tck), 32'd0);
        chk("R3", "tck period ps", 32'(int'((t_rise_last - t_rise_prev) * 1000.0)),
            32'(2 * CLK_DIV * 5000));
        repeat (20) @(negedge clk);
        chk("R12", "done held", 32'(done), 32'd1);
        chk("R12", "busy low", 32'(busy), 32'd0);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        finish_up();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset values
        chk("R1", "tck", 32'(tck), 32'd0);
        chk("R1", "tms", 32'(tms), 32'd1);
        chk("R1", "tdi", 32'(tdi), 32'd0);
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "no_chain", 32'(no_chain), 32'd0);
        chk("R1", "overflow", 32'(overflow), 32'd0);
        chk("R1", "dev_count", 32'(dev_count), 32'd0);
        chk("R1", "id_count", 32'(id_count), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R6 R7 R12: mixed chain from a stray IR state, extra start mid-scan
        mode = 0; ndev = 3;
        is_id[0] = 1; code[0] = 32'h0128_1043;
        is_id[1] = 0; code[1] = 32'h0;
        is_id[2] = 1; code[2] = 32'h4BA0_0477;
        run_scan(T_SHI, 1'b1);

        // R10: nine IDCODEs
        ndev = 9;
        for (int d = 0; d < 9; d++) begin
            is_id[d] = 1;
            code[d]  = 32'h1000_0001 + (32'(d) << 16) + (32'(d) << 4);
        end
        run_scan(T_PDR, 1'b0);

        // R9: bypass only, earlier slots must read back as zero
        ndev = 2;
        is_id[0] = 0; is_id[1] = 0;
        run_scan(T_RTI, 1'b0);

        // R11: TDO stuck low, then stuck high
        mode = 1;
        run_scan(T_TLR, 1'b0);
        mode = 2;
        run_scan(T_UDR, 1'b0);

        finish_up();
    end
endmodule